// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer Base

This block is the time base of a timer channel group. A programmable prescaler divides the input clock into counter ticks. The counter runs against an auto-reload limit in one of five ways: edge-aligned upward, edge-aligned downward, or symmetric up-then-down in three center-aligned flavours. Each completed counting period produces an update event. The event reloads the active prescaler and limit from their shadow copies, pulses a strobe and sets a sticky interrupt flag.

Software drives a small write port and a single-cycle software-update input. Attached compare channels read the counter value, the counting direction and a qualifier. The qualifier tells them whether a compare match may raise a flag in the present direction. The three center-aligned flavours differ only in that qualifier. An update-request-source bit lets a software update refresh the active registers without raising the interrupt flag.

Top module: `tmr_base`

## Requirements
- R1: In edge-aligned up mode (mode field 0, direction bit 0), the counter steps 0,1,..,L and then returns to 0, where L is the active reload value. The update strobe pulses once per wrap, so the period is L+1 ticks.
- R2: In edge-aligned down mode (mode field 0, direction bit 1), the counter steps down from L to 0, then reloads L and pulses the update strobe. The period is L+1 ticks.
- R3: In center-aligned modes (mode field 1, 2 or 3), the counter climbs from 0 to L and falls back to 0. The update strobe pulses when it reaches 0, so the period is 2*L ticks for L of 1 or more.
- R4: The compare qualifier output is 1 in edge-aligned mode and in mode 3. It equals the down-direction bit in mode 1 and its inverse in mode 2.
- R5: A counter tick occurs once every P+1 clock cycles while enabled, where P is the active prescaler. A prescaler write (address 1) becomes active only at the next update event.
- R6: With the update-request bit set (control bit 5), a software update still pulses the strobe and reloads the active registers, but it leaves the flag unchanged. Counter wraps set the flag regardless of this bit.
- R7: With reload preload on (control bit 4), a reload write (address 2) reaches the active limit only at the next update event. With preload off, it applies at once.
- R8: A control write (address 0) issued while the enable bit (control bit 0) is 1 leaves the direction bit (bit 1) and the mode field (bits 3:2) unchanged.
- R9: A software update pulse clears the prescaler divider and sets the counter to 0, or to the new reload value in edge-aligned down mode. It sets the center-aligned direction to up, and the strobe pulses one cycle later.
- R10: The update flag stays set until a write to address 3 with bit 0 equal to 0. A flag-setting event in the same cycle as that clear wins.
- R11: The direction output reflects control bit 1 in edge-aligned mode. In center-aligned modes it turns to down in the tick that reaches L and back to up in the tick that reaches 0.
- R12: After reset, the counter is 0, the flag and strobe are 0, the direction is up, the mode is edge-aligned and the counter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 prescaler, 2 reload, 3 flag |
| wr_data | input | DAT_W | Write data |
| sw_upd_i | input | 1 | Software update request pulse |
| cnt_o | output | CNT_W | Counter value |
| dir_down_o | output | 1 | 1 while counting down |
| upd_o | output | 1 | Update event strobe |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_qual_o | output | 1 | Compare flags permitted in current direction |

## Verification
The hardest states to reach are coincidences. Examples are a flag clear landing in the same cycle as a setting event, a software update colliding with a counter tick, and a shrunken reload value arriving while the counter already sits above it. Directed sequences force the first two by issuing the pulse and the write in one cycle. A cycle-accurate bench model then follows a long seeded random mix of small reload and prescaler values, mode changes and sparse software updates, which lands on shrink-below-counter and zero-limit cases repeatedly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CMS_EDGE = 2'd0,
    CMS_DN   = 2'd1,
    CMS_UP   = 2'd2,
    CMS_BOTH = 2'd3
  } cms_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_PSC  = 2'd1;
  localparam logic [1:0] ADR_ARR  = 2'd2;
  localparam logic [1:0] ADR_FLAG = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_DIR  = 1;
  localparam int B_CMS  = 2;
  localparam int B_ARPE = 4;
  localparam int B_URS  = 5;
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int DAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             sw_upd,
  input  logic             cnt_upd,
  output logic             en,
  output logic             dn,
  output cms_e             cms,
  output logic [PSC_W-1:0] psc_act,
  output logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] arr_sh,
  output logic             flag
);
  logic             arpe, urs;
  logic [PSC_W-1:0] psc_sh;
  logic             en_n, dn_n, arpe_n, urs_n, flag_n;
  cms_e             cms_n;
  logic [PSC_W-1:0] psc_sh_n, psc_act_n;
  logic [CNT_W-1:0] arr_sh_n, arr_act_n;
  logic             upd_evt, flag_set, flag_clr;
  logic             wr_ctrl, wr_psc, wr_arr, wr_flag;

  assign upd_evt  = cnt_upd | sw_upd;
  assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_psc   = wr_en && (wr_addr == ADR_PSC);
  assign wr_arr   = wr_en && (wr_addr == ADR_ARR);
  assign wr_flag  = wr_en && (wr_addr == ADR_FLAG);
  assign flag_set = cnt_upd | (sw_upd & ~urs);
  assign flag_clr = wr_flag & ~wr_data[0];

  always_comb begin
    en_n      = en;
    dn_n      = dn;
    cms_n     = cms;
    arpe_n    = arpe;
    urs_n     = urs;
    psc_sh_n  = psc_sh;
    psc_act_n = psc_act;
    arr_sh_n  = arr_sh;
    arr_act_n = arr_act;
    if (wr_ctrl) begin
      en_n   = wr_data[B_EN];
      arpe_n = wr_data[B_ARPE];
      urs_n  = wr_data[B_URS];
      if (!en) begin
        dn_n  = wr_data[B_DIR];
        cms_n = cms_e'(wr_data[B_CMS+1:B_CMS]);
      end
    end
    if (upd_evt) begin
      psc_act_n = psc_sh;
      arr_act_n = arr_sh;
    end
    if (wr_psc) psc_sh_n = wr_data[PSC_W-1:0];
    if (wr_arr) begin
      arr_sh_n = wr_data[CNT_W-1:0];
      if (!arpe) arr_act_n = wr_data[CNT_W-1:0];
    end
    if (flag_set)      flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    else               flag_n = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      dn      <= 1'b0;
      cms     <= CMS_EDGE;
      arpe    <= 1'b0;
      urs     <= 1'b0;
      psc_sh  <= '0;
      psc_act <= '0;
      arr_sh  <= '0;
      arr_act <= '0;
      flag    <= 1'b0;
    end else begin
      en      <= en_n;
      dn      <= dn_n;
      cms     <= cms_n;
      arpe    <= arpe_n;
      urs     <= urs_n;
      psc_sh  <= psc_sh_n;
      psc_act <= psc_act_n;
      arr_sh  <= arr_sh_n;
      arr_act <= arr_act_n;
      flag    <= flag_n;
    end
  end

  assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && en) |=> ($stable(cms) && $stable(dn)));

  assert_preload_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_arr && arpe && !upd_evt) |=> $stable(arr_act));

  assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(cnt_upd || (sw_upd && !urs)));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc_act,
  output logic             tick
);
  logic [PSC_W-1:0] div_q, div_n;

  assign tick = en && (div_q == psc_act);

  always_comb begin
    div_n = div_q;
    if (clr || tick) div_n = '0;
    else if (en)     div_n = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  assert_div_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= psc_act);
endmodule

// File: rtl/tmr_counter_core.sv
module tmr_counter_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_upd,
  input  cms_e             cms,
  input  logic             dn,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [CNT_W-1:0] arr_sh,
  output logic [CNT_W-1:0] cnt,
  output logic             cdn,
  output logic             cnt_upd
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_n;
  logic             cdn_n;
  logic [EXT_W-1:0] inc_ext;

  assign inc_ext = {1'b0, cnt} + 1'b1;

  always_comb begin
    cnt_n   = cnt;
    cdn_n   = cdn;
    cnt_upd = 1'b0;
    if (sw_upd) begin
      cnt_n = (cms == CMS_EDGE && dn) ? arr_sh : '0;
      cdn_n = 1'b0;
    end else if (tick) begin
      if (cms == CMS_EDGE) begin
        if (!dn) begin
          if (cnt >= arr_act) begin
            cnt_n   = '0;
            cnt_upd = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            cnt_n   = arr_sh;
            cnt_upd = 1'b1;
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
      end else begin
        if (!cdn) begin
          if (inc_ext >= {1'b0, arr_act}) begin
            cnt_n = arr_act;
            cdn_n = 1'b1;
          end else begin
            cnt_n = inc_ext[CNT_W-1:0];
          end
        end else begin
          if (cnt <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
            cnt_n   = '0;
            cdn_n   = 1'b0;
            cnt_upd = 1'b1;
          end else begin
            cnt_n = cnt - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cdn <= 1'b0;
    end else begin
      cnt <= cnt_n;
      cdn <= cdn_n;
    end
  end

  assert_up_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_upd && cms == CMS_EDGE && !dn) |=> (cnt == '0));

  assert_center_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_upd && cms != CMS_EDGE) |=> (cnt == '0 && !cdn));

  assert_sw_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd && cms != CMS_EDGE) |=> (cnt == '0 && !cdn));
endmodule

// File: rtl/tmr_base.sv
module tmr_base
  import tmr_pkg::*;
#(
  parameter int  CNT_W = 16,
  parameter int  PSC_W = 16,
  localparam int DAT_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             sw_upd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_down_o,
  output logic             upd_o,
  output logic             upd_flag_o,
  output logic             cmp_qual_o
);
  logic             en, dn, cdn, tick, cnt_upd, upd_q;
  cms_e             cms;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act, arr_sh;

  tmr_cfg_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DAT_W(DAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_upd(sw_upd_i), .cnt_upd(cnt_upd),
    .en(en), .dn(dn), .cms(cms), .psc_act(psc_act),
    .arr_act(arr_act), .arr_sh(arr_sh), .flag(upd_flag_o)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(sw_upd_i),
    .psc_act(psc_act), .tick(tick)
  );

  tmr_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_upd(sw_upd_i),
    .cms(cms), .dn(dn), .arr_act(arr_act), .arr_sh(arr_sh),
    .cnt(cnt_o), .cdn(cdn), .cnt_upd(cnt_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= cnt_upd | sw_upd_i;
  end
  assign upd_o = upd_q;

  always_comb begin
    dir_down_o = (cms == CMS_EDGE) ? dn : cdn;
    unique case (cms)
      CMS_DN:  cmp_qual_o = cdn;
      CMS_UP:  cmp_qual_o = ~cdn;
      default: cmp_qual_o = 1'b1;
    endcase
  end

  assert_strobe_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !$past(sw_upd_i)) |-> upd_flag_o);

  assert_qual_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cms == CMS_EDGE || cms == CMS_BOTH) |-> cmp_qual_o);
endmodule

// File: tb/tmr_base_test.sv
module tmr_base_test;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [W-1:0]  wr_data = '0;
  logic          sw_upd = 1'b0;
  logic [W-1:0]  cnt_o;
  logic          dir_down_o, upd_o, upd_flag_o, cmp_qual_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  tmr_base #(.CNT_W(W), .PSC_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_upd_i(sw_upd), .cnt_o(cnt_o),
    .dir_down_o(dir_down_o), .upd_o(upd_o), .upd_flag_o(upd_flag_o),
    .cmp_qual_o(cmp_qual_o)
  );

  always #10 clk = ~clk;

  // reference model state
  logic         m_en, m_dn, m_arpe, m_urs, m_flag, m_cdn, m_upd;
  logic [1:0]   m_cms;
  logic [W-1:0] m_psc_sh, m_psc, m_arr_sh, m_arr, m_cnt, m_div;

  function automatic logic exp_dir();
    return (m_cms == 2'd0) ? m_dn : m_cdn;
  endfunction

  function automatic logic exp_qual();
    case (m_cms)
      2'd1:    return m_cdn;
      2'd2:    return ~m_cdn;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_dn = 0; m_arpe = 0; m_urs = 0; m_flag = 0; m_cdn = 0;
      m_upd = 0; m_cms = 0; m_psc_sh = 0; m_psc = 0; m_arr_sh = 0;
      m_arr = 0; m_cnt = 0; m_div = 0;
    end else begin
      logic tk, cu, nen, ndn, narpe, nurs, ncdn, nflag;
      logic [1:0] ncms;
      logic [W-1:0] ncnt, ndiv, npsc_sh, npsc, narr_sh, narr;
      tk = m_en && (m_div == m_psc);
      cu = 0; ncnt = m_cnt; ncdn = m_cdn;
      if (sw_upd) begin
        ncnt = (m_cms == 0 && m_dn) ? m_arr_sh : '0;
        ncdn = 0;
      end else if (tk) begin
        if (m_cms == 0 && !m_dn) begin
          if (m_cnt >= m_arr) begin ncnt = 0; cu = 1; end
          else ncnt = m_cnt + 1;
        end else if (m_cms == 0) begin
          if (m_cnt == 0) begin ncnt = m_arr_sh; cu = 1; end
          else ncnt = m_cnt - 1;
        end else if (!m_cdn) begin
          if (32'(m_cnt) + 1 >= 32'(m_arr)) begin ncnt = m_arr; ncdn = 1; end
          else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt <= 1) begin ncnt = 0; ncdn = 0; cu = 1; end
          else ncnt = m_cnt - 1;
        end
      end
      ndiv = (sw_upd || tk) ? '0 : (m_en ? m_div + 1 : m_div);
      nen = m_en; ndn = m_dn; ncms = m_cms; narpe = m_arpe; nurs = m_urs;
      npsc_sh = m_psc_sh; npsc = m_psc; narr_sh = m_arr_sh; narr = m_arr;
      if (wr_en && wr_addr == 2'd0) begin
        nen = wr_data[0]; narpe = wr_data[4]; nurs = wr_data[5];
        if (!m_en) begin ndn = wr_data[1]; ncms = wr_data[3:2]; end
      end
      if (cu || sw_upd) begin npsc = m_psc_sh; narr = m_arr_sh; end
      if (wr_en && wr_addr == 2'd1) npsc_sh = wr_data;
      if (wr_en && wr_addr == 2'd2) begin
        narr_sh = wr_data;
        if (!m_arpe) narr = wr_data;
      end
      if (cu || (sw_upd && !m_urs)) nflag = 1;
      else if (wr_en && wr_addr == 2'd3 && !wr_data[0]) nflag = 0;
      else nflag = m_flag;
      m_upd = cu | sw_upd;
      m_cnt = ncnt; m_cdn = ncdn; m_div = ndiv; m_en = nen; m_dn = ndn;
      m_cms = ncms; m_arpe = narpe; m_urs = nurs; m_psc_sh = npsc_sh;
      m_psc = npsc; m_arr_sh = narr_sh; m_arr = narr; m_flag = nflag;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_cms == 0 ? (m_dn ? "R2" : "R1") : "R3", "cnt", cnt_o, m_cnt);
      chk("R11", "dir", {15'd0, dir_down_o}, {15'd0, exp_dir()});
      chk("R4", "qual", {15'd0, cmp_qual_o}, {15'd0, exp_qual()});
      chk("R5", "upd", {15'd0, upd_o}, {15'd0, m_upd});
      chk("R10", "flag", {15'd0, upd_flag_o}, {15'd0, m_flag});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_sw();
    sw_upd = 1;
    @(negedge clk);
    sw_upd = 0;
  endtask

  task automatic period(output int n);
    int guard = 0;
    n = 0;
    while (!upd_o && guard < 400) begin @(negedge clk); guard++; end
    @(negedge clk); n = 1;
    while (!upd_o && n < 400) begin @(negedge clk); n++; end
  endtask

  initial begin
    int p;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "cnt", cnt_o, 0);
    chk("R12", "flag", {15'd0, upd_flag_o}, 0);
    chk("R12", "upd", {15'd0, upd_o}, 0);
    chk("R12", "dir", {15'd0, dir_down_o}, 0);

    // R1 edge up, reload 3 -> period 4
    wr(2'd2, 3);
    wr(2'd0, 16'h0001);
    period(p); chk("R1", "up period", p, 4);

    // R9 software update while running in up mode
    repeat (2) @(negedge clk);
    pulse_sw();
    chk("R9", "cnt after sw", cnt_o, 0);
    chk("R9", "strobe after sw", {15'd0, upd_o}, 1);

    // R5 prescaler 2 -> period 12 after next update
    wr(2'd1, 2);
    period(p); period(p); chk("R5", "psc period", p, 12);

    // R8 mode write while enabled is ignored
    wr(2'd0, 16'h000D);
    chk("R8", "dir", {15'd0, dir_down_o}, 0);
    chk("R8", "qual", {15'd0, cmp_qual_o}, 1);
    period(p); period(p); chk("R8", "period kept", p, 12);

    // R2 edge down
    wr(2'd0, 0);
    wr(2'd1, 0);
    pulse_sw();
    wr(2'd0, 16'h0003);
    chk("R11", "edge dir down", {15'd0, dir_down_o}, 1);
    period(p); chk("R2", "down period", p, 4);

    // R3/R4/R11 center mode 1
    wr(2'd0, 0);
    wr(2'd0, 16'h0005);
    period(p); chk("R3", "center period", p, 6);
    chk("R4", "qual up in mode1", {15'd0, cmp_qual_o}, 0);
    chk("R11", "dir at 0", {15'd0, dir_down_o}, 0);
    repeat (3) @(negedge clk);
    chk("R11", "cnt at top", cnt_o, 3);
    chk("R11", "dir at top", {15'd0, dir_down_o}, 1);
    chk("R4", "qual down in mode1", {15'd0, cmp_qual_o}, 1);

    // R7 preload: new reload waits for the update, then period 8
    wr(2'd0, 0);
    wr(2'd3, 0);
    wr(2'd0, 16'h0031);
    wr(2'd2, 7);
    p = 0;
    while (!upd_o && p < 400) begin @(negedge clk); p++; end
    chk("R7", "old limit still active", {15'd0, p <= 4}, 1);
    period(p); chk("R7", "new period", p, 8);
    chk("R6", "wrap sets flag", {15'd0, upd_flag_o}, 1);

    // R6 software update with counter-only request source
    wr(2'd0, 16'h0030);
    wr(2'd3, 0);
    pulse_sw();
    chk("R6", "strobe", {15'd0, upd_o}, 1);
    chk("R6", "flag untouched", {15'd0, upd_flag_o}, 0);

    // R10 set wins over clear; writing 1 does nothing
    wr(2'd0, 0);
    sw_upd = 1; wr_en = 1; wr_addr = 2'd3; wr_data = 0;
    @(negedge clk);
    sw_upd = 0; wr_en = 0;
    chk("R10", "set beats clear", {15'd0, upd_flag_o}, 1);
    wr(2'd3, 1);
    chk("R10", "write one keeps", {15'd0, upd_flag_o}, 1);
    wr(2'd3, 0);
    chk("R10", "clear", {15'd0, upd_flag_o}, 0);

    // random phase, checked every cycle against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6) begin
        wr_en = 1; wr_addr = 2'd0;
        wr_data = W'($urandom & 32'h3E) | W'($urandom_range(0, 9) != 0);
      end else if (r < 9) begin
        wr_en = 1; wr_addr = 2'd1; wr_data = W'($urandom_range(0, 3));
      end else if (r < 14) begin
        wr_en = 1; wr_addr = 2'd2; wr_data = W'($urandom_range(0, 15));
      end else if (r < 17) begin
        wr_en = 1; wr_addr = 2'd3; wr_data = W'($urandom_range(0, 1));
      end else begin
        wr_en = 0;
      end
      sw_upd = ($urandom_range(0, 99) < 2);
      @(negedge clk);
    end
    wr_en = 0; sw_upd = 0;
    @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule